// File: doc/BRIEF.md
# Programmable Test Pulse Train Generator

This block drives one digital output with a train of test pulses. Software sets the low time, the high time and the number of phase transitions through a small register interface, then starts the train. A train can start at once, or it can wait for a timestamp reset strobe and begin after a programmed delay, so that injected hits land at known timestamps. A status bit shows whether a train is in progress.

All times are counted in clock ticks (4 ns at the intended 250 MHz). Phase lengths and the delay are stored as the wanted tick count minus one. The count register holds the number of phase transitions, which is twice the number of pulses. A zero count runs the train until another train is started. Starting a train always replaces the one that is running, so a continuous train is stopped by starting a short finite train.

Top module: `pulse_train_gen`

## Requirements
- R1: After synchronous reset `pulse_out` and `busy` are 0, and every readable register (addresses 0, 1, 2, 4, 5) reads 0.
- R2: Writes to address 0 (low length), 1 (high length), 2 (transition count) and 4 (delay) store the low 24, 24, 16 and 16 bits of `wr_data`, and reading the same address returns that value with upper bits zero. Address 5 reads `{armed, busy}` in bits 1:0.
- R3: Writing address 3 with `wr_data[0]`=1 sets `busy` on the next cycle with `pulse_out` low. The low phase lasts low length + 1 cycles, then `pulse_out` rises and stays high for high length + 1 cycles, and the phases alternate from then on.
- R4: With a non-zero count C, the train makes exactly C transitions. `busy` falls on the same cycle as the final transition, and after that `pulse_out` is low.
- R5: With a count of 0 the train alternates without end until a new train is started.
- R6: A start while a train is running abandons the old train. The new train begins from its low phase using the current register values.
- R7: Writing address 4 sets the armed flag. A `ts_reset` strobe while armed clears the flag and sets `busy` with `pulse_out` low. `pulse_out` rises after delay + 1 cycles, and that rising edge is counted as the first transition.
- R8: A `ts_reset` strobe while the block is not armed has no effect on `pulse_out`, `busy` or the status register.
- R9: With an odd count the train ends on a rising transition, and `pulse_out` is forced low on that same cycle.
- R10: A write to address 3 with `wr_data[0]`=0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| ts_reset | input | 1 | One-cycle timestamp reset strobe |
| pulse_out | output | 1 | Test pulse output, low when idle |
| busy | output | 1 | A train, or its start delay, is in progress |

## Verification
A phase counter off by one shows up on the first edge after a start, within low length + 2 cycles. A wrong transition count or a lost continuous flag shows up at the end of a train, where `busy` stays up too long or drops too early. A stale armed flag shows up as a train that starts on an unarmed strobe, or as a wrong bit 1 at address 5. The bench compares `pulse_out` and `busy` with its model on every cycle, so any of these faults is reported on the cycle it first reaches the ports.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [2:0] {
    REG_LOW    = 3'd0,
    REG_HIGH   = 3'd1,
    REG_COUNT  = 3'd2,
    REG_FIRE   = 3'd3,
    REG_DELAY  = 3'd4,
    REG_STATUS = 3'd5
  } reg_addr_e;

  // Reload value of the phase timer for the phase that follows a transition.
  function automatic logic [31:0] next_phase_len(input logic now_high,
                                                 input logic [31:0] low_len,
                                                 input logic [31:0] high_len);
    return now_high ? low_len : high_len;
  endfunction

  // Transitions still to go after one more has been made.
  function automatic logic [31:0] after_step(input logic [31:0] remaining);
    return remaining - 32'd1;
  endfunction
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs import ptg_pkg::*; #(
  parameter int PHASE_W = 24,
  parameter int COUNT_W = 16,
  parameter int DELAY_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [2:0]         rd_addr,
  input  logic               ts_reset,
  input  logic               busy,
  output logic [DATA_W-1:0]  rd_data,
  output logic [PHASE_W-1:0] low_len,
  output logic [PHASE_W-1:0] high_len,
  output logic [COUNT_W-1:0] edge_total,
  output logic [DELAY_W-1:0] delay_len,
  output logic               armed,
  output logic               fire_evt,
  output logic               arm_trig
);
  logic wr_delay;

  assign fire_evt = wr_en && (wr_addr == REG_FIRE) && wr_data[0];
  assign arm_trig = ts_reset && armed;
  assign wr_delay = wr_en && (wr_addr == REG_DELAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len    <= '0;
      high_len   <= '0;
      edge_total <= '0;
      delay_len  <= '0;
      armed      <= 1'b0;
    end else begin
      if (wr_en && wr_addr == REG_LOW)   low_len    <= wr_data[PHASE_W-1:0];
      if (wr_en && wr_addr == REG_HIGH)  high_len   <= wr_data[PHASE_W-1:0];
      if (wr_en && wr_addr == REG_COUNT) edge_total <= wr_data[COUNT_W-1:0];
      if (wr_delay) begin
        delay_len <= wr_data[DELAY_W-1:0];
        armed     <= 1'b1;
      end else if (arm_trig) begin
        armed <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_LOW:    rd_data[PHASE_W-1:0] = low_len;
      REG_HIGH:   rd_data[PHASE_W-1:0] = high_len;
      REG_COUNT:  rd_data[COUNT_W-1:0] = edge_total;
      REG_DELAY:  rd_data[DELAY_W-1:0] = delay_len;
      REG_STATUS: rd_data[1:0]         = {armed, busy};
      default:    rd_data = '0;
    endcase
  end

  // R7
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_trig && !wr_delay) |=> !armed);
  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_delay |=> armed);
endmodule

// File: rtl/ptg_phase_timer.sv
module ptg_phase_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ptg_edge_counter.sv
module ptg_edge_counter import ptg_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_val,
  input  logic         step,
  output logic         last
);
  logic [W-1:0] remaining;
  logic         endless;
  logic [31:0]  stepped;

  assign stepped = after_step(32'(remaining));
  assign last    = step && !endless && (remaining == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      endless   <= 1'b0;
    end else if (start) begin
      remaining <= start_val;
      endless   <= (start_val == '0);
    end else if (step && !endless) begin
      remaining <= stepped[W-1:0];
    end
  end

  // R5
  endless_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (endless && !start) |=> endless);
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen import ptg_pkg::*; #(
  parameter int PHASE_W = 24,
  parameter int COUNT_W = 16,
  parameter int DELAY_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ts_reset,
  output logic              pulse_out,
  output logic              busy
);
  logic [PHASE_W-1:0] low_len, high_len, load_val;
  logic [COUNT_W-1:0] edge_total;
  logic [DELAY_W-1:0] delay_len;
  logic armed, fire_evt, arm_trig;
  logic start_evt, phase_expire, step_evt, last_evt;
  logic [31:0] reload_val;

  ptg_regs #(.PHASE_W(PHASE_W), .COUNT_W(COUNT_W), .DELAY_W(DELAY_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ts_reset(ts_reset), .busy(busy), .rd_data(rd_data),
    .low_len(low_len), .high_len(high_len), .edge_total(edge_total),
    .delay_len(delay_len), .armed(armed), .fire_evt(fire_evt), .arm_trig(arm_trig)
  );

  assign start_evt  = fire_evt || arm_trig;
  assign step_evt   = phase_expire && !start_evt;
  assign reload_val = next_phase_len(pulse_out, 32'(low_len), 32'(high_len));

  always_comb begin
    if (fire_evt)      load_val = low_len;
    else if (arm_trig) load_val = PHASE_W'(delay_len);
    else               load_val = reload_val[PHASE_W-1:0];
  end

  ptg_phase_timer #(.W(PHASE_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .load(start_evt || phase_expire),
    .load_val(load_val), .expire(phase_expire)
  );

  ptg_edge_counter #(.W(COUNT_W)) u_edges (
    .clk(clk), .rst(rst), .start(start_evt), .start_val(edge_total),
    .step(step_evt), .last(last_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pulse_out <= 1'b0;
    end else if (start_evt) begin
      busy      <= 1'b1;
      pulse_out <= 1'b0;
    end else if (last_evt) begin
      busy      <= 1'b0;
      pulse_out <= 1'b0;
    end else if (step_evt) begin
      pulse_out <= !pulse_out;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pulse_out);
  // R3
  fire_start_chk: assert property (@(posedge clk) disable iff (rst)
    fire_evt |=> (busy && !pulse_out));
  // R7
  arm_start_chk: assert property (@(posedge clk) disable iff (rst)
    arm_trig |=> (busy && !pulse_out));
  // R4
  final_edge_chk: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> (!busy && !pulse_out));
  // R8
  idle_ts_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && ts_reset && !armed && !fire_evt) |=> !busy);
  // R3
  toggle_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pulse_out) |-> $past(phase_expire || start_evt));
endmodule

// File: tb/pulse_train_gen_bench.sv
module pulse_train_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic ts_reset = 1'b0;
  logic [31:0] rd_data;
  logic pulse_out, busy;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int m_lo = 0, m_hi = 0, m_cnt = 0, m_dly = 0;
  bit m_armed = 0, m_run = 0, m_lvl = 0;
  int m_left = 0, m_tot = 0, m_tleft = 0;

  always #5 clk = ~clk;

  pulse_train_gen u_pulse_train_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ts_reset(ts_reset),
    .pulse_out(pulse_out), .busy(busy)
  );

  always @(posedge clk) begin
    bit do_fire, do_trig;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_cnt = 0; m_dly = 0;
      m_armed = 0; m_run = 0; m_lvl = 0; m_left = 0; m_tot = 0; m_tleft = 0;
    end else begin
      do_fire = wr_en && wr_addr == 3'd3 && wr_data[0];
      do_trig = ts_reset && m_armed;
      if (m_run) begin
        m_left--;
        if (m_left == 0) begin
          m_lvl = !m_lvl;
          if (m_tot != 0) begin
            m_tleft--;
            if (m_tleft == 0) begin m_run = 0; m_lvl = 0; end
          end
          m_left = m_lvl ? m_hi + 1 : m_lo + 1;
        end
      end
      if (do_fire || do_trig) begin
        m_run = 1; m_lvl = 0; m_tot = m_cnt; m_tleft = m_cnt;
        m_left = do_fire ? m_lo + 1 : m_dly + 1;
      end
      if (do_trig) m_armed = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_lo  = int'(wr_data[23:0]);
          3'd1: m_hi  = int'(wr_data[23:0]);
          3'd2: m_cnt = int'(wr_data[15:0]);
          3'd4: begin m_dly = int'(wr_data[15:0]); m_armed = 1; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pulse_out !== m_lvl || busy !== m_run) begin
        errors++;
        $display("FAIL %s pulse_out/busy actual %0b/%0b expected %0b/%0b at %0t",
                 cur_req, pulse_out, busy, m_lvl, m_run, $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe_ts();
    @(negedge clk);
    ts_reset = 1'b1;
    @(negedge clk);
    ts_reset = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    rd_check(3'd0, 32'h0, "R1");
    rd_check(3'd2, 32'h0, "R1");
    rd_check(3'd4, 32'h0, "R1");
    rd_check(3'd5, 32'h0, "R1");
    // R2 field widths and readback
    cur_req = "R2";
    wr(3'd0, 32'hFF00_0003);
    wr(3'd1, 32'hAB00_0001);
    wr(3'd2, 32'hABCD_0004);
    rd_check(3'd0, 32'h3, "R2");
    rd_check(3'd1, 32'h1, "R2");
    rd_check(3'd2, 32'h4, "R2");
    // R10 fire with bit0 clear
    cur_req = "R10";
    wr(3'd3, 32'hFFFF_FFFE);
    idle(10);
    rd_check(3'd5, 32'h0, "R10");
    // R3/R4 two pulses, low 4 cycles, high 2 cycles
    cur_req = "R3_R4";
    wr(3'd3, 32'h1);
    rd_check(3'd5, 32'h1, "R3");
    idle(25);
    // R9 odd count
    cur_req = "R9";
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h1);
    idle(25);
    // R5 continuous
    cur_req = "R5";
    wr(3'd0, 32'd2);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h1);
    idle(60);
    // R6 stop by finite restart
    cur_req = "R6";
    wr(3'd0, 32'd5);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'h1);
    idle(4);
    wr(3'd3, 32'h1);
    idle(25);
    rd_check(3'd5, 32'h0, "R6");
    // R8 unarmed strobe ignored
    cur_req = "R8";
    strobe_ts();
    idle(8);
    rd_check(3'd5, 32'h0, "R8");
    // R7 delayed start
    cur_req = "R7";
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd4);
    wr(3'd4, 32'hFFFF_0006);
    rd_check(3'd4, 32'h6, "R2");
    rd_check(3'd5, 32'h2, "R7");
    idle(3);
    strobe_ts();
    rd_check(3'd5, 32'h1, "R7");
    idle(25);
    rd_check(3'd5, 32'h0, "R7");
    // R7 odd count in delayed mode ends on the rise
    cur_req = "R7_R9";
    wr(3'd2, 32'd1);
    wr(3'd4, 32'd2);
    strobe_ts();
    idle(12);
    cur_req = "R8";
    strobe_ts();
    idle(6);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule